// File: doc/BRIEF.md
# Boot Window Command Sequencer

The sequencer sits on a flash controller's register write port and interprets writes that fall into either of two small boot address windows as boot commands. It recognises three commands: a warm-reset request; an identify command that fills the first three words of the boot buffer with identity bytes; and a two-step page load. In the page load, a first write arms the sequencer and a following zero write requests a full page transfer into data buffer 0 and then advances the page address.

The block keeps its own block-address and page-address registers. These registers are written through the same write port at two fixed register offsets. On each page-load request, their values travel with a one-cycle request pulse. The page transfer itself, the boot buffer storage and the action of the warm reset are all handled outside the block. A sticky flag records that a boot write carried a value that is not a command.

Top module: `boot_cmd_sequencer`

## Requirements
- R1: After reset, `load_req`, `warm_req` and `bb_we` are low, `unk_cmd` is low, the sequencer is not armed, and the block and page registers are zero.
- R2: Only writes whose address lies in 0x0000..0x01FF or 0x8000..0x800F are treated as boot commands. A command value written anywhere else produces no request, no boot buffer write and no flag.
- R3: A boot write of 0x00F0 while not armed pulses `warm_req` for one cycle, starting the cycle after the write. It clears the block and page registers to zero and cancels any identify sequence still in progress.
- R4: A boot write of 0x00E0 while not armed arms the sequencer. The next boot write of 0x0000 pulses `load_req` for one cycle, starting the cycle after the write, with `load_blk` and `load_page` equal to the register values before that write.
- R5: While armed, any boot write disarms the sequencer. A non-zero value written while armed does nothing else: it is not decoded as a command, and a later 0x0000 does not load.
- R6: A boot write of 0x0090 while not armed produces three consecutive boot buffer writes, to words 0, 1 and 2. Their data are the low bytes of `mfr_id`, `dev_id` and `wp_status`, zero-extended, captured at the time of the command.
- R7: A boot write while not armed whose value is none of 0x00F0, 0x00E0 and 0x0090 sets `unk_cmd`. No other output changes. `unk_cmd` stays set until `rst_n` is asserted, and a warm reset does not clear it.
- R8: After each page-load request, the page register becomes (old value + 4) modulo 256, with its upper byte cleared.
- R9: Writes outside the boot windows neither arm nor disarm the sequencer.
- R10: A write to offset 0xF100 loads the block register, and a write to offset 0xF107 loads the page register, with all 16 bits of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 16 | Write word offset |
| wr_data | input | 16 | Write data |
| mfr_id | input | 16 | Manufacturer identity value |
| dev_id | input | 16 | Device identity value |
| wp_status | input | 16 | Current write-protect status |
| warm_req | output | 1 | One-cycle warm reset request |
| load_req | output | 1 | One-cycle page load request |
| load_blk | output | 16 | Block address for the load |
| load_page | output | 16 | Page address for the load |
| bb_we | output | 1 | Boot buffer word write enable |
| bb_addr | output | 2 | Boot buffer word index |
| bb_wdata | output | 16 | Boot buffer write data |
| unk_cmd | output | 1 | Sticky unknown boot command flag |

## Verification
The page-step assertion assumes that the page register is not written through its own offset in the same cycle that a load fires. This holds because the port accepts only one address per cycle. The identify sequence assumes that the identity inputs may change after the command is issued, since their values are captured at that point. The stimulus drives one write per cycle and keeps identify and warm-reset commands apart, except in the deliberate abort case. The stimulus also holds the identity values steady around each identify command, so that each expected word is fixed.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam logic [15:0] BOOT_CMD_WARM  = 16'h00F0;
  localparam logic [15:0] BOOT_CMD_ARM   = 16'h00E0;
  localparam logic [15:0] BOOT_CMD_IDENT = 16'h0090;
  localparam logic [15:0] BOOT_CMD_FIRE  = 16'h0000;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WARM,
    ACT_ARM,
    ACT_FIRE,
    ACT_DISARM,
    ACT_IDENT,
    ACT_UNKNOWN
  } boot_act_e;
endpackage

// File: rtl/boot_seq_window.sv
module boot_seq_window #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] WIN0_LO = 16'h0000,
  parameter logic [AW-1:0] WIN0_HI = 16'h01FF,
  parameter logic [AW-1:0] WIN1_LO = 16'h8000,
  parameter logic [AW-1:0] WIN1_HI = 16'h800F,
  parameter logic [AW-1:0] BLK_OFS = 16'hF100,
  parameter logic [AW-1:0] PAGE_OFS = 16'hF107
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          hit_boot,
  output logic          hit_blk,
  output logic          hit_page
);
  localparam int unsigned NWIN = 2;
  localparam logic [NWIN-1:0][AW-1:0] LO = {WIN1_LO, WIN0_LO};
  localparam logic [NWIN-1:0][AW-1:0] HI = {WIN1_HI, WIN0_HI};

  logic [NWIN-1:0] in_win;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign in_win[w] = (wr_addr >= LO[w]) && (wr_addr <= HI[w]);
  end

  assign hit_boot = wr_en && (|in_win);
  assign hit_blk  = wr_en && (wr_addr == BLK_OFS);
  assign hit_page = wr_en && (wr_addr == PAGE_OFS);
endmodule

// File: rtl/boot_seq_addr_regs.sv
module boot_seq_addr_regs #(
  parameter int unsigned DW = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned PAGE_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          blk_we,
  input  logic          page_we,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] page_q
);
  localparam logic [DW-1:0] PAGE_MASK = DW'((1 << PAGE_W) - 1);
  localparam logic [DW-1:0] STEP_V = DW'(PAGE_STEP);

  logic [DW-1:0] blk_d, page_d;
  logic          blk_en, page_en;

  always_comb begin
    blk_d   = blk_q;
    page_d  = page_q;
    blk_en  = 1'b0;
    page_en = 1'b0;
    if (clr) begin
      blk_d   = '0;
      page_d  = '0;
      blk_en  = 1'b1;
      page_en = 1'b1;
    end else begin
      if (blk_we) begin
        blk_d  = wdata;
        blk_en = 1'b1;
      end
      if (page_we) begin
        page_d  = wdata;
        page_en = 1'b1;
      end else if (step) begin
        page_d  = (page_q + STEP_V) & PAGE_MASK;
        page_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      page_q <= '0;
    end else begin
      if (blk_en)  blk_q  <= blk_d;
      if (page_en) page_q <= page_d;
    end
  end

  // R8: a page step without a competing write lands on old + step, wrapped
  p_page_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !page_we && !clr) |=> (page_q == (($past(page_q) + STEP_V) & PAGE_MASK)));

  // R3: a clear leaves both registers at zero
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (blk_q == '0 && page_q == '0));
endmodule

// File: rtl/boot_seq_id_writer.sv
module boot_seq_id_writer #(
  parameter int unsigned DW = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ID_WORDS = 3,
  localparam int unsigned CW = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             abort,
  input  logic [ID_WORDS-1:0][BYTE_W-1:0]  id_bytes,
  output logic                             we,
  output logic [CW-1:0]                    addr,
  output logic [DW-1:0]                    wdata
);
  localparam logic [CW-1:0] LAST = CW'(ID_WORDS - 1);

  logic                            busy_q, busy_d;
  logic [CW-1:0]                   cnt_q, cnt_d;
  logic [ID_WORDS-1:0][BYTE_W-1:0] cap_q;
  logic                            cap_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cap_en = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cap_en = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (cap_en) cap_q <= id_bytes;
    end
  end

  assign we    = busy_q;
  assign addr  = cnt_q;
  assign wdata = DW'(cap_q[cnt_q]);

  // R6: the word index never leaves the identity area
  p_word_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (addr <= LAST));

  // R6: words follow one another without gaps until the last one
  p_word_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != LAST && !start && !abort) |=> (we && addr == $past(addr) + 1'b1));

  // R6: the sequence stops after the last word unless restarted
  p_word_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == LAST && !start) |=> !we);
endmodule

// File: rtl/boot_cmd_sequencer.sv
module boot_cmd_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned PAGE_STEP = 4,
  localparam int unsigned ID_WORDS = 3,
  localparam int unsigned BB_AW = $clog2(ID_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    mfr_id,
  input  logic [DW-1:0]    dev_id,
  input  logic [DW-1:0]    wp_status,
  output logic             warm_req,
  output logic             load_req,
  output logic [DW-1:0]    load_blk,
  output logic [DW-1:0]    load_page,
  output logic             bb_we,
  output logic [BB_AW-1:0] bb_addr,
  output logic [DW-1:0]    bb_wdata,
  output logic             unk_cmd
);
  logic hit_boot, hit_blk, hit_page;
  logic [DW-1:0] blk_q, page_q;
  boot_act_e act;

  logic armed_q, armed_d;
  logic unk_q, unk_d;
  logic warm_q, warm_d;
  logic load_q, load_d;
  logic [DW-1:0] lblk_q, lpage_q;

  boot_seq_window #(.AW(AW)) u_window (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .hit_boot(hit_boot),
    .hit_blk (hit_blk),
    .hit_page(hit_page)
  );

  // command decode: armed state consumes the write, otherwise match values
  always_comb begin
    act = ACT_NONE;
    if (hit_boot) begin
      if (armed_q) begin
        act = (wr_data == DW'(BOOT_CMD_FIRE)) ? ACT_FIRE : ACT_DISARM;
      end else begin
        unique case (wr_data)
          DW'(BOOT_CMD_WARM):  act = ACT_WARM;
          DW'(BOOT_CMD_ARM):   act = ACT_ARM;
          DW'(BOOT_CMD_IDENT): act = ACT_IDENT;
          default:             act = ACT_UNKNOWN;
        endcase
      end
    end
  end

  always_comb begin
    armed_d = armed_q;
    unique case (act)
      ACT_ARM:                     armed_d = 1'b1;
      ACT_FIRE, ACT_DISARM,
      ACT_WARM:                    armed_d = 1'b0;
      default:                     armed_d = armed_q;
    endcase
    unk_d  = unk_q | (act == ACT_UNKNOWN);
    warm_d = (act == ACT_WARM);
    load_d = (act == ACT_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      unk_q   <= 1'b0;
      warm_q  <= 1'b0;
      load_q  <= 1'b0;
      lblk_q  <= '0;
      lpage_q <= '0;
    end else begin
      armed_q <= armed_d;
      unk_q   <= unk_d;
      warm_q  <= warm_d;
      load_q  <= load_d;
      if (load_d) begin
        lblk_q  <= blk_q;
        lpage_q <= page_q;
      end
    end
  end

  boot_seq_addr_regs #(
    .DW(DW), .PAGE_W(PAGE_W), .PAGE_STEP(PAGE_STEP)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (act == ACT_WARM),
    .blk_we (hit_blk),
    .page_we(hit_page),
    .step   (act == ACT_FIRE),
    .wdata  (wr_data),
    .blk_q  (blk_q),
    .page_q (page_q)
  );

  logic [ID_WORDS-1:0][7:0] id_bytes;
  assign id_bytes = {wp_status[7:0], dev_id[7:0], mfr_id[7:0]};

  boot_seq_id_writer #(
    .DW(DW), .BYTE_W(8), .ID_WORDS(ID_WORDS)
  ) u_ident (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (act == ACT_IDENT),
    .abort   (act == ACT_WARM),
    .id_bytes(id_bytes),
    .we      (bb_we),
    .addr    (bb_addr),
    .wdata   (bb_wdata)
  );

  assign warm_req  = warm_q;
  assign load_req  = load_q;
  assign load_blk  = lblk_q;
  assign load_page = lpage_q;
  assign unk_cmd   = unk_q;

  // R4: a load request only follows a cycle in which the sequencer was armed
  p_load_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> $past(armed_q));

  // R4: the load request is a single-cycle pulse
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  // R3: a warm reset request leaves the sequencer disarmed with cleared registers
  p_warm_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm_req |-> (!armed_q && blk_q == '0 && page_q == '0));

  // R7: the unknown-command flag never drops while out of reset
  p_unk_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unk_cmd |=> unk_cmd);

  // R5: while armed, no warm reset or identify can start
  p_armed_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hit_boot) |=> (!warm_req && !$rose(bb_we)));
endmodule

// File: tb/boot_cmd_sequencer_test.sv
module boot_cmd_sequencer_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr, wr_data, mfr_id, dev_id, wp_status;
  logic        warm_req, load_req, bb_we, unk_cmd;
  logic [15:0] load_blk, load_page, bb_wdata;
  logic [1:0]  bb_addr;

  boot_cmd_sequencer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mfr_id(mfr_id), .dev_id(dev_id), .wp_status(wp_status),
    .warm_req(warm_req), .load_req(load_req), .load_blk(load_blk), .load_page(load_page),
    .bb_we(bb_we), .bb_addr(bb_addr), .bb_wdata(bb_wdata), .unk_cmd(unk_cmd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef enum int { EV_LOAD, EV_WARM, EV_BBW } ev_kind_e;
  typedef struct {
    ev_kind_e    kind;
    logic [15:0] a;
    logic [15:0] b;
    string       req;
  } ev_t;

  ev_t exp_q[$];
  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  // bench-side model of the address registers and the armed state
  logic [15:0] m_blk = 16'h0, m_page = 16'h0;
  bit          m_armed = 0;

  function automatic bit in_boot(input logic [15:0] a);
    return (a <= 16'h01FF) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic push(input ev_kind_e k, input logic [15:0] a, input logic [15:0] b,
                      input string req);
    ev_t e;
    e.kind = k; e.a = a; e.b = b; e.req = req;
    exp_q.push_back(e);
  endtask

  // driver: one write per call, predictions pushed from the requirements
  task automatic wr(input logic [15:0] a, input logic [15:0] d, input string req);
    if (a == 16'hF100) m_blk = d;
    else if (a == 16'hF107) m_page = d;
    else if (in_boot(a)) begin
      if (m_armed) begin
        m_armed = 0;
        if (d == 16'h0000) begin
          push(EV_LOAD, m_blk, m_page, req);
          m_page = (m_page + 16'd4) & 16'h00FF;
        end
      end else if (d == 16'h00F0) begin
        push(EV_WARM, 16'h0, 16'h0, req);
        m_blk = 0; m_page = 0;
      end else if (d == 16'h00E0) begin
        m_armed = 1;
      end else if (d == 16'h0090) begin
        push(EV_BBW, 16'd0, {8'h00, mfr_id[7:0]}, req);
        push(EV_BBW, 16'd1, {8'h00, dev_id[7:0]}, req);
        push(EV_BBW, 16'd2, {8'h00, wp_status[7:0]}, req);
      end
    end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wr_en = 1'b0; wr_addr = 16'h0; wr_data = 16'h0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per observed event
  task automatic take(input ev_kind_e k, input logic [15:0] a, input logic [15:0] b);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected output event", {16'h0, a}, 32'hFFFF);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == k, e.req, "event kind", k, e.kind);
    check(e.a == a, e.req, "event field a", a, e.a);
    check(e.b == b, e.req, "event field b", b, e.b);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (load_req) take(EV_LOAD, load_blk, load_page);
      if (warm_req) take(EV_WARM, 16'h0, 16'h0);
      if (bb_we)    take(EV_BBW, {14'h0, bb_addr}, bb_wdata);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 0; wr_data = 0;
    mfr_id = 16'h11AB; dev_id = 16'h22CD; wp_status = 16'h0004;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!load_req && !warm_req && !bb_we, "R1", "pulses low in reset",
          {load_req, warm_req, bb_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!unk_cmd, "R1", "unknown flag after reset", unk_cmd, 0);
    // R1: registers start at zero, seen through a load
    wr(16'h0000, 16'h00E0, "R1"); wr(16'h0000, 16'h0000, "R1"); idle(3);

    // R10 / R4: load registers then arm and fire in both windows
    wr(16'hF100, 16'h0123, "R10"); wr(16'hF107, 16'h0010, "R10");
    wr(16'h0000, 16'h00E0, "R4");  wr(16'h01FF, 16'h0000, "R4"); idle(2);
    wr(16'h8000, 16'h00E0, "R4");  wr(16'h800F, 16'h0000, "R4"); idle(2);

    // R9 / R8: outside write while armed keeps the arm; page wraps past 0xFF
    wr(16'hF107, 16'h12FC, "R8");
    wr(16'h8005, 16'h00E0, "R9"); wr(16'h0200, 16'h0000, "R9");
    wr(16'h0010, 16'h0000, "R9"); idle(2);
    wr(16'h0000, 16'h00E0, "R8"); wr(16'h0000, 16'h0000, "R8"); idle(2);

    // R2: commands outside the windows
    wr(16'h0200, 16'h00F0, "R2"); wr(16'h8010, 16'h00F0, "R2");
    wr(16'h7FFF, 16'h0090, "R2"); wr(16'hF000, 16'h1234, "R2"); idle(3);
    check(!unk_cmd, "R2", "no flag from outside writes", unk_cmd, 0);

    // R5: armed then non-zero disarms without acting; a later zero is unknown
    wr(16'h0000, 16'h00E0, "R5"); wr(16'h0000, 16'h00F0, "R5"); idle(2);
    check(!unk_cmd, "R5", "disarming write not decoded", unk_cmd, 0);
    wr(16'h0000, 16'h0000, "R5"); idle(2);
    check(unk_cmd, "R5", "zero after disarm is not a load", unk_cmd, 1);
    wr(16'h0000, 16'h00E0, "R5"); wr(16'h0000, 16'h00E0, "R5");
    wr(16'h0000, 16'h0000, "R5"); idle(2);

    // R7: unknown value keeps flag set
    wr(16'h8001, 16'h1234, "R7"); idle(2);
    check(unk_cmd, "R7", "flag stays set", unk_cmd, 1);

    // R6: identify sequence with captured low bytes
    wr(16'h0100, 16'h0090, "R6");
    mfr_id = 16'hFFFF; dev_id = 16'hFFFF; wp_status = 16'hFFFF;
    idle(5);
    mfr_id = 16'h3377; dev_id = 16'h4488; wp_status = 16'h0002;
    wr(16'h8000, 16'h0090, "R6"); idle(5);

    // R3: warm reset clears registers; flag survives
    wr(16'hF100, 16'h0055, "R3"); wr(16'hF107, 16'h0030, "R3");
    wr(16'h0000, 16'h00F0, "R3"); idle(2);
    check(unk_cmd, "R7", "flag survives warm reset", unk_cmd, 1);
    wr(16'h0000, 16'h00E0, "R3"); wr(16'h0000, 16'h0000, "R3"); idle(2);

    // R3: warm reset right after identify aborts the remaining words
    wr(16'h0000, 16'h0090, "R3");
    exp_q.delete(exp_q.size() - 1);
    exp_q.delete(exp_q.size() - 1);
    wr(16'h0000, 16'h00F0, "R3"); idle(5);

    check(exp_q.size() == 0, "R4", "all expected events seen", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule